// File: doc/BRIEF.md
# Reset and Programming-Mode Entry Detector

This block watches two raw device pins, the reset pin and the program-store strobe, while the oscillator runs. It decides when to drive the chip-wide reset. When that reset ends, it decides whether the device starts normal execution or enters the mode in which an external host programs the device.

Both pins pass through synchronizer chains before any logic uses them. Reset length is measured in machine cycles, using a one-clock tick that arrives every 12 oscillator clocks in standard operation or every 6 in double-speed operation. A falling edge on the strobe only counts if it arrives while the reset pin is high. The reset pin must also stay high for more than the host threshold of machine cycles. The mode is fixed at the moment reset is released and does not change until the next reset.

A separate active-low power-on reset sets the block's own registers. During power-on reset the device reset is driven and both mode flags are low.

Top module: `rst_mode_detect`

## Requirements
- R1: While `arst_n` is low, `dev_rst` is 1 and both mode flags are 0. Once `arst_n` is high and the reset pin is low, `dev_rst` drops and `normal_mode` becomes 1.
- R2: If the reset pin stays high for at least RST_CYC machine-cycle ticks (default 2), `dev_rst` is asserted. `dev_rst` stays asserted until the synchronized reset pin goes low.
- R3: A reset-pin pulse that spans fewer than RST_CYC ticks has no effect: `dev_rst` stays 0 and the mode flags keep their values.
- R4: If the strobe has a falling edge (1 to 0) while the reset pin is high, and the reset pin stays high for more than HOST_CYC ticks (default 10), then `host_mode` is 1 and `normal_mode` is 0 after release.
- R5: A reset with no strobe falling edge during it ends with `normal_mode` 1 and `host_mode` 0.
- R6: A reset that sees a strobe falling edge but lasts HOST_CYC ticks or fewer ends in normal mode.
- R7: The tick count starts again from zero whenever the reset pin goes low, so separate short pulses do not add up to a reset.
- R8: While `dev_rst` is 1, both mode flags are 0. After release, exactly one flag is 1, and it holds through strobe activity until the next reset.
- R9: Thresholds are counted in ticks, not in clocks. With 6-clock ticks, a given number of oscillator clocks spans twice as many machine cycles as with 12-clock ticks.
- R10: A strobe falling edge that occurs while the reset pin is low is not counted toward host-mode entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Active-low power-on reset of the block |
| rst_pin | input | 1 | Raw, asynchronous reset pin, active high |
| psen_pin | input | 1 | Raw, asynchronous program-store strobe pin |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| dev_rst | output | 1 | Internal device reset, active high |
| host_mode | output | 1 | External host programming mode selected |
| normal_mode | output | 1 | Normal operation selected |

## Verification
The bench builds the block with its default values: RST_CYC of 2, HOST_CYC of 10 and two synchronizer stages. With these values a single 12-clock tick window sits just below the reset threshold. An eight-cycle reset lands between the reset threshold and the host threshold. The bench drives the tick itself at both 12 and 6 clocks. This lets one fixed pin-high duration fall on either side of the host threshold, depending only on tick spacing.

// File: rtl/rst_mode_detect.sv
module rst_mode_detect #(
  parameter int RST_CYC     = 2,
  parameter int HOST_CYC    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  input  logic psen_pin,
  input  logic mc_tick,
  output logic dev_rst,
  output logic host_mode,
  output logic normal_mode
);
  localparam int CMAX = HOST_CYC + 1;
  localparam int CW   = $clog2(CMAX + 1);

  logic [SYNC_STAGES-1:0] rst_sh, psen_sh;
  logic                   psen_d, fall_seen;
  logic [CW-1:0]          cnt;

  wire rst_s     = rst_sh[SYNC_STAGES-1];
  wire psen_s    = psen_sh[SYNC_STAGES-1];
  wire psen_fall = psen_d & ~psen_s;
  wire release_e = dev_rst & ~rst_s;
  wire arm       = rst_s & mc_tick & (cnt == CW'(RST_CYC - 1));
  wire long_hold = (cnt == CW'(CMAX));

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      rst_sh  <= '0;
      psen_sh <= '1;
      psen_d  <= 1'b1;
    end else begin
      rst_sh  <= {rst_sh[SYNC_STAGES-2:0], rst_pin};
      psen_sh <= {psen_sh[SYNC_STAGES-2:0], psen_pin};
      psen_d  <= psen_s;
    end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                       cnt <= '0;
    else if (!rst_s)                   cnt <= '0;
    else if (mc_tick && !long_hold)    cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)        fall_seen <= 1'b0;
    else if (!rst_s)    fall_seen <= 1'b0;
    else if (psen_fall) fall_seen <= 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      dev_rst     <= 1'b1;
      host_mode   <= 1'b0;
      normal_mode <= 1'b0;
    end else if (release_e) begin
      dev_rst     <= 1'b0;
      host_mode   <= fall_seen & long_hold;
      normal_mode <= ~(fall_seen & long_hold);
    end else if (arm) begin
      dev_rst     <= 1'b1;
      host_mode   <= 1'b0;
      normal_mode <= 1'b0;
    end
endmodule

// File: rtl/rst_mode_detect_chk.sv
module rst_mode_detect_chk (
  input logic clk,
  input logic arst_n,
  input logic mc_tick,
  input logic dev_rst,
  input logic host_mode,
  input logic normal_mode
);
  // R8
  flags_quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    dev_rst |-> (!host_mode && !normal_mode));

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({host_mode, normal_mode}));

  // R8
  flags_held_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!dev_rst && !$past(dev_rst)) |-> ($stable(host_mode) && $stable(normal_mode)));

  // R2
  reset_on_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(dev_rst) |-> $past(mc_tick));

  // R5
  release_picks_mode_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(dev_rst) |-> (host_mode || normal_mode));
endmodule

bind rst_mode_detect rst_mode_detect_chk u_chk (
  .clk(clk), .arst_n(arst_n), .mc_tick(mc_tick),
  .dev_rst(dev_rst), .host_mode(host_mode), .normal_mode(normal_mode)
);

// File: tb/rst_mode_detect_test.sv
module rst_mode_detect_test;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_pin = 1'b0;
  logic psen_pin = 1'b1;
  logic mc_tick = 1'b0;
  logic dev_rst, host_mode, normal_mode;

  int total = 0;
  int bad = 0;
  int tick_div = 12;
  int tick_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_mode_detect uut (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .psen_pin(psen_pin),
    .mc_tick(mc_tick), .dev_rst(dev_rst), .host_mode(host_mode),
    .normal_mode(normal_mode)
  );

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt <= 0;
      mc_tick  <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      mc_tick  <= 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int hi_clks, int fall_at, output bit saw);
    saw = 1'b0;
    @(negedge clk);
    rst_pin = 1'b1;
    for (int i = 0; i < hi_clks; i++) begin
      @(negedge clk);
      if (dev_rst) saw = 1'b1;
      if (i == fall_at) psen_pin = 1'b0;
    end
    rst_pin = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (dev_rst) saw = 1'b1;
    end
    psen_pin = 1'b1;
    idle(8);
  endtask

  task automatic t_por();
    check("R1 dev_rst in por", dev_rst, 1);
    check("R1 flags in por", {host_mode, normal_mode}, 0);
    @(negedge clk); arst_n = 1'b1;
    idle(10);
    check("R1 dev_rst released", dev_rst, 0);
    check("R1 normal after por", {host_mode, normal_mode}, 2'b01);
  endtask

  task automatic t_short();
    bit saw;
    pulse(12, -1, saw);
    check("R3 short pulse no reset", saw, 0);
    check("R3 flags kept", {host_mode, normal_mode}, 2'b01);
  endtask

  task automatic t_restart();
    bit saw;
    @(negedge clk); rst_pin = 1'b1;
    idle(12);
    rst_pin = 1'b0;
    idle(3);
    rst_pin = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dev_rst) saw = 1'b1;
    end
    rst_pin = 1'b0;
    idle(10);
    check("R7 pulses do not accumulate", saw, 0);
  endtask

  task automatic t_host();
    bit saw;
    pulse(480, 300, saw);
    check("R2 long hold resets", saw, 1);
    check("R4 host selected", {host_mode, normal_mode}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      psen_pin = 1'b0; idle(5); psen_pin = 1'b1; idle(5);
    end
    check("R8 host held", {host_mode, normal_mode, dev_rst}, 3'b100);
  endtask

  task automatic t_no_fall();
    bit saw;
    pulse(480, -1, saw);
    check("R2 reset asserted", saw, 1);
    check("R5 normal without edge", {host_mode, normal_mode}, 2'b01);
  endtask

  task automatic t_too_short_host();
    bit saw;
    pulse(96, 40, saw);
    check("R2 eight cycles reset", saw, 1);
    check("R6 edge but short hold", {host_mode, normal_mode}, 2'b01);
  endtask

  task automatic t_fall_while_low();
    bit saw;
    @(negedge clk); psen_pin = 1'b0;
    idle(6);
    pulse(480, -1, saw);
    check("R10 low-time edge ignored", {host_mode, normal_mode}, 2'b01);
  endtask

  task automatic t_fast_ticks();
    bit saw;
    pulse(90, 20, saw);
    check("R9 slow ticks 90 clocks normal", {host_mode, normal_mode}, 2'b01);
    tick_div = 6;
    idle(12);
    pulse(90, 20, saw);
    check("R9 fast ticks 90 clocks host", {host_mode, normal_mode}, 2'b10);
    pulse(48, 20, saw);
    check("R9 fast ticks eight cycles normal", {host_mode, normal_mode}, 2'b01);
    tick_div = 12;
    idle(12);
  endtask

  initial begin
    idle(5);
    t_por();
    t_short();
    t_restart();
    t_host();
    t_no_fall();
    t_too_short_host();
    t_fall_while_low();
    t_fast_ticks();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule